// File: doc/BRIEF.md
# Byte-Serial CRC-16 Checksum Engine

This block computes the 16-bit cyclic check used by a common serial fieldbus. It uses the reflected polynomial 0xA001 with an all-ones preset. Bytes are fed in one at a time through a valid/ready handshake, and the running remainder is always visible on `crc_o`. The same engine serves both directions of a link, and a mode is picked each time a frame is cleared.

In generate mode, every accepted byte goes into the remainder. A start strobe then sends out the two check bytes, low byte first. In check mode, the engine holds back the two most recent bytes, so the remainder only ever covers the bytes before them. Once the frame has ended, the engine compares the two held bytes against the remainder and reports either a match or a mismatch. On a mismatch, the surrounding logic drops the frame without replying.

A parameter sets how many shift steps happen per clock. At one step per clock, the engine stays busy for several cycles after each byte. At eight steps per clock, it takes a byte every cycle.

Top module: `mbcrc_engine`

## Requirements
- R1: After reset or a clear strobe (`clr_i`), the following hold on the next cycle: `crc_o` = 0xFFFF, `in_ready_o` = 1, `out_valid_o` = 0, no bytes are held, and `check_ok_o` = `check_bad_o` = 0.
- R2: An accepted byte is XORed into bits 7:0 of the remainder. The remainder then takes eight steps. Each step shifts right by one and XORs in 0xA001 when the bit shifted out was 1. In generate mode, bytes 01 03 00 00 00 01 give `crc_o` = 0x0A84.
- R3: In generate mode, a `gen_start_i` accepted while `in_ready_o` = 1 has the following effect. From the next cycle, `out_valid_o` is high for exactly two cycles. `out_byte_o` carries `crc_o[7:0]` and then `crc_o[15:8]`, and `crc_o` does not change during this time.
- R4: With BITS_PER_CLK steps per cycle, `in_ready_o` stays low for 8/BITS_PER_CLK - 1 cycles after each accepted byte. During emission it is also low. A byte offered while it is low is ignored.
- R5: `mode_i` is sampled on the `clr_i` cycle: 0 selects generate, 1 selects check.
- R6: In check mode, the two most recent bytes are held back and left out of `crc_o`. Once at least two bytes have arrived and the engine is idle, `check_ok_o` = 1 if the older held byte equals `crc_o[7:0]` and the newer one equals `crc_o[15:8]`.
- R7: Under the conditions of R6, a mismatch in either held byte raises `check_bad_o` instead of `check_ok_o`.
- R8: While fewer than two bytes are held, or while `in_ready_o` is low, `check_ok_o` and `check_bad_o` are both 0.
- R9: `gen_start_i` is ignored in check mode and while `in_ready_o` is low, so `out_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Start a new frame: preset the remainder and latch the mode |
| mode_i | input | 1 | 0 = generate, 1 = check (sampled with `clr_i`) |
| in_valid_i | input | 1 | An input byte is offered |
| in_byte_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Engine can take a byte or a start strobe |
| gen_start_i | input | 1 | Start sending the two check bytes |
| out_valid_o | output | 1 | `out_byte_o` carries a check byte |
| out_byte_o | output | 8 | Check byte, low byte first |
| crc_o | output | 16 | Running remainder |
| check_ok_o | output | 1 | Held check bytes match the remainder |
| check_bad_o | output | 1 | Held check bytes differ from the remainder |

## Verification
The embedded assertions cover the timing rules on every cycle:
- the preset after a clear;
- ready falling after an accepted byte;
- the second emitted byte following the first;
- the remainder staying frozen during emission;
- emission only ever happening in generate mode;
- both verdict flags staying low while the engine is busy;
- the holding window shifting correctly.

The arithmetic itself can only be shown by the bench's scenarios. These cover the known vector, a second frame compared against an independent model, and good frames and frames with a corrupt low or high check byte. They also show that a byte offered while busy leaves the remainder untouched, and that the verdict stays silent for frames that are too short.

// File: rtl/mbcrc_pkg.sv
package mbcrc_pkg;

    typedef enum logic [1:0] {
        EM_IDLE = 2'd0,
        EM_LO   = 2'd1,
        EM_HI   = 2'd2
    } emit_e;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } mode_e;

endpackage

// File: rtl/mbcrc_update.sv
// Combinational remainder update: STEPS_PER_CALL reflected shift steps.
module mbcrc_update #(
    parameter int          CRC_W          = 16,
    parameter logic [15:0] POLY           = 16'hA001,
    parameter int          STEPS_PER_CALL = 1
) (
    input  logic [CRC_W-1:0] cur_i,
    output logic [CRC_W-1:0] nxt_o
);
    logic [CRC_W-1:0] chain [0:STEPS_PER_CALL];

    assign chain[0] = cur_i;

    for (genvar g = 0; g < STEPS_PER_CALL; g++) begin : g_step
        assign chain[g+1] = chain[g][0] ? ((chain[g] >> 1) ^ CRC_W'(POLY))
                                        : (chain[g] >> 1);
    end

    assign nxt_o = chain[STEPS_PER_CALL];
endmodule

// File: rtl/mbcrc_window.sv
// Two-byte holding window for check mode.
module mbcrc_window #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              full_o,
    output logic [BYTE_W-1:0] old_o,
    output logic [BYTE_W-1:0] new_o
);
    typedef struct packed {
        logic [1:0]        cnt;
        logic [BYTE_W-1:0] old_b;
        logic [BYTE_W-1:0] new_b;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (clr_i) begin
            win_d.cnt = 2'd0;
        end else if (push_i) begin
            win_d.old_b = win_q.new_b;
            win_d.new_b = byte_i;
            if (win_q.cnt != 2'd2) begin
                win_d.cnt = win_q.cnt + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign full_o = (win_q.cnt == 2'd2);
    assign old_o  = win_q.old_b;
    assign new_o  = win_q.new_b;

    // R6
    win_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clr_i) |=> (new_o == $past(byte_i) && old_o == $past(new_o)));

    // R1
    win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !full_o);
endmodule

// File: rtl/mbcrc_engine.sv
module mbcrc_engine #(
    parameter int          BYTE_W       = 8,
    parameter int          BITS_PER_CLK = 1,
    parameter logic [15:0] POLY         = 16'hA001,
    parameter logic [15:0] PRESET       = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              mode_i,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_byte_i,
    output logic              in_ready_o,
    input  logic              gen_start_i,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic [2*BYTE_W-1:0] crc_o,
    output logic              check_ok_o,
    output logic              check_bad_o
);
    import mbcrc_pkg::*;

    localparam int CRC_W = 2 * BYTE_W;
    localparam int STEPS = BYTE_W / BITS_PER_CLK;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CNT_W-1:0] steps;
        mode_e            mode;
        emit_e            emit;
    } eng_t;

    eng_t st_d, st_q;

    logic              accept;
    logic              win_push;
    logic              win_full;
    logic [BYTE_W-1:0] win_old;
    logic [BYTE_W-1:0] win_new;
    logic [BYTE_W-1:0] feed;
    logic              feed_en;
    logic [CRC_W-1:0]  seed;
    logic [CRC_W-1:0]  upd;
    logic              idle;

    assign idle       = (st_q.steps == '0) && (st_q.emit == EM_IDLE);
    assign in_ready_o = idle;
    assign accept     = in_valid_i && idle;
    assign win_push   = accept && (st_q.mode == MODE_CHK);

    mbcrc_window #(.BYTE_W(BYTE_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .push_i (win_push),
        .byte_i (in_byte_i),
        .full_o (win_full),
        .old_o  (win_old),
        .new_o  (win_new)
    );

    // The byte entering the remainder: direct in generate mode, or the one
    // leaving the holding window in check mode.
    always_comb begin
        if (st_q.mode == MODE_CHK) begin
            feed    = win_old;
            feed_en = win_full;
        end else begin
            feed    = in_byte_i;
            feed_en = 1'b1;
        end
    end

    assign seed = (st_q.steps != '0) ? st_q.crc
                                     : (st_q.crc ^ {{BYTE_W{1'b0}}, feed});

    mbcrc_update #(
        .CRC_W          (CRC_W),
        .POLY           (POLY),
        .STEPS_PER_CALL (BITS_PER_CLK)
    ) u_upd (
        .cur_i (seed),
        .nxt_o (upd)
    );

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.crc   = CRC_W'(PRESET);
            st_d.steps = '0;
            st_d.mode  = mode_e'(mode_i);
            st_d.emit  = EM_IDLE;
        end else if (st_q.steps != '0) begin
            st_d.crc   = upd;
            st_d.steps = st_q.steps - CNT_W'(1);
        end else if (st_q.emit == EM_LO) begin
            st_d.emit = EM_HI;
        end else if (st_q.emit == EM_HI) begin
            st_d.emit = EM_IDLE;
        end else if (accept) begin
            if (feed_en) begin
                st_d.crc   = upd;
                st_d.steps = CNT_W'(STEPS - 1);
            end
        end else if (gen_start_i && st_q.mode == MODE_GEN) begin
            st_d.emit = EM_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc   <= CRC_W'(PRESET);
            st_q.steps <= '0;
            st_q.mode  <= MODE_GEN;
            st_q.emit  <= EM_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_o       = st_q.crc;
    assign out_valid_o = (st_q.emit != EM_IDLE);
    assign out_byte_o  = (st_q.emit == EM_HI) ? st_q.crc[CRC_W-1:BYTE_W]
                                              : st_q.crc[BYTE_W-1:0];

    logic verdict_en;
    logic held_match;
    assign verdict_en  = (st_q.mode == MODE_CHK) && win_full && idle;
    assign held_match  = (win_old == st_q.crc[BYTE_W-1:0]) &&
                         (win_new == st_q.crc[CRC_W-1:BYTE_W]);
    assign check_ok_o  = verdict_en && held_match;
    assign check_bad_o = verdict_en && !held_match;

    // R1
    clr_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (crc_o == CRC_W'(PRESET) && in_ready_o && !out_valid_o));

    // R3
    emit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.emit == EM_LO && !clr_i) |=>
            (out_valid_o && out_byte_o == $past(crc_o[CRC_W-1:BYTE_W])));

    // R3
    emit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !clr_i) |=> $stable(crc_o));

    // R4
    if (STEPS > 1) begin : g_busy_chk
        busy_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid_i && in_ready_o && !clr_i && (st_q.mode == MODE_GEN))
                |=> !in_ready_o);
    end

    // R9
    emit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (st_q.mode == MODE_GEN));

    // R8
    quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready_o |-> (!check_ok_o && !check_bad_o));
endmodule

// File: tb/tb_mbcrc_engine.sv
module tb_mbcrc_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       mode_i = 1'b0;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_byte_i = 8'h00;
    logic       in_ready_o;
    logic       gen_start_i = 1'b0;
    logic       out_valid_o;
    logic [7:0] out_byte_o;
    logic [15:0] crc_o;
    logic       check_ok_o;
    logic       check_bad_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q[$];
    logic [7:0] fr [0:15];

    always #4 clk = ~clk;

    mbcrc_engine dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mode_i(mode_i),
        .in_valid_i(in_valid_i), .in_byte_i(in_byte_i), .in_ready_o(in_ready_o),
        .gen_start_i(gen_start_i), .out_valid_o(out_valid_o), .out_byte_o(out_byte_o),
        .crc_o(crc_o), .check_ok_o(check_ok_o), .check_bad_o(check_bad_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int n);
        logic [15:0] r = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            r ^= {8'h00, fr[i]};
            for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        end
        return r;
    endfunction

    // Monitor: pops expected check bytes as the design emits them.
    always @(negedge clk) begin
        if (rst_n && out_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R9 unexpected byte", out_byte_o, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(out_byte_o == e, "R3 emitted byte", out_byte_o, e);
            end
        end
    end

    task automatic do_clr(input logic m);
        @(negedge clk); clr_i = 1'b1; mode_i = m;
        @(negedge clk); clr_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready_o) @(negedge clk);
        in_valid_i = 1'b1; in_byte_i = b;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (!in_ready_o) @(negedge clk);
    endtask

    task automatic send_frame(input int n);
        for (int i = 0; i < n; i++) send(fr[i]);
        wait_idle();
    endtask

    task automatic emit(input logic [15:0] r);
        exp_q.push_back(r[7:0]);
        exp_q.push_back(r[15:8]);
        @(negedge clk); gen_start_i = 1'b1;
        @(negedge clk); gen_start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!out_valid_o, "R3 two bytes only", out_valid_o, 0);
        chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
    endtask

    task automatic load_base();
        fr[0] = 8'h01; fr[1] = 8'h03; fr[2] = 8'h00; fr[3] = 8'h00;
        fr[4] = 8'h00; fr[5] = 8'h01; fr[6] = 8'h84; fr[7] = 8'h0A;
    endtask

    initial begin : watchdog
        #(8 * 100000);
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int busy;
        logic [15:0] m;
        repeat (3) @(negedge clk);
        chk(crc_o == 16'hFFFF, "R1 reset crc", crc_o, 16'hFFFF);
        chk(in_ready_o && !out_valid_o, "R1 reset ready", {in_ready_o, out_valid_o}, 2'b10);
        rst_n = 1'b1;

        // R2 known vector, R5 generate mode, R3 emission order
        do_clr(1'b0);
        load_base();
        send_frame(6);
        chk(crc_o == 16'h0A84, "R2 known vector", crc_o, 16'h0A84);
        emit(16'h0A84);

        // R4 busy length and an ignored byte while busy
        do_clr(1'b0);
        chk(crc_o == 16'hFFFF, "R1 clear preset", crc_o, 16'hFFFF);
        fr[0] = 8'h11; fr[1] = 8'h06; fr[2] = 8'h00; fr[3] = 8'h2A;
        fr[4] = 8'h12; fr[5] = 8'h34;
        send(fr[0]);
        busy = 0;
        while (!in_ready_o) begin busy++; @(negedge clk); end
        chk(busy == 7, "R4 busy cycles", busy, 7);
        send(fr[1]);
        in_valid_i = 1'b1; in_byte_i = 8'hFF;
        repeat (3) @(negedge clk);
        in_valid_i = 1'b0;
        wait_idle();
        m = model(2);
        chk(crc_o == m, "R4 byte ignored while busy", crc_o, m);
        for (int i = 2; i < 6; i++) send(fr[i]);
        wait_idle();
        m = model(6);
        chk(crc_o == m, "R2 second frame", crc_o, m);
        emit(m);

        // R6 good frame in check mode
        do_clr(1'b1);
        load_base();
        send(fr[0]);
        chk(!check_ok_o && !check_bad_o, "R8 one byte held", {check_ok_o, check_bad_o}, 0);
        for (int i = 1; i < 8; i++) send(fr[i]);
        chk(!check_ok_o && !check_bad_o, "R8 quiet while busy", {check_ok_o, check_bad_o}, 0);
        wait_idle();
        chk(check_ok_o && !check_bad_o, "R6 good frame", {check_ok_o, check_bad_o}, 2'b10);
        chk(crc_o == 16'h0A84, "R6 check bytes excluded", crc_o, 16'h0A84);

        // R9 start ignored in check mode
        @(negedge clk); gen_start_i = 1'b1;
        @(negedge clk); gen_start_i = 1'b0;
        chk(!out_valid_o, "R9 no emission in check mode", out_valid_o, 0);
        @(negedge clk);
        chk(!out_valid_o, "R9 no emission in check mode", out_valid_o, 0);

        // R7 low byte corrupted
        do_clr(1'b1);
        load_base(); fr[6] = 8'h85;
        send_frame(8);
        chk(check_bad_o && !check_ok_o, "R7 bad low byte", {check_ok_o, check_bad_o}, 2'b01);

        // R7 high byte corrupted
        do_clr(1'b1);
        load_base(); fr[7] = 8'h0B;
        send_frame(8);
        chk(check_bad_o && !check_ok_o, "R7 bad high byte", {check_ok_o, check_bad_o}, 2'b01);

        // R1 clear empties the window
        do_clr(1'b1);
        chk(!check_ok_o && !check_bad_o, "R1 clear empties window", {check_ok_o, check_bad_o}, 0);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule